// File: doc/BRIEF.md
# Vector Length Configuration Unit

This execution unit carries out the instruction that configures the vector length of a scalar-vector processor. The issue stage presents a 32-bit instruction word, the value read from the general-purpose register named by the source field, the current vector-length and maximum-length special registers, and the summary-overflow bit. The unit decodes the word and computes the new maximum length and the new vector length. It clamps the length to the maximum. One clock after the request it returns a registered result: write enables and data for both special registers, an optional destination-register write and an optional update of condition field 0.

Lengths in the immediate are stored minus one, so a six-bit field covers 1 to 64. A length of zero is reachable only through a register operand. The vector length can come from three places: the source register, the immediate, or the value it already holds. Two mode bits in the word choose between them. The maximum length is either reloaded from the immediate or kept. A word whose primary opcode or extended-opcode bits do not belong to this unit is flagged as not-mine. A word with the reserved immediate bit set is flagged illegal. Neither of these writes anything.

Top module: `vl_cfg_unit`

## Requirements
- R1: A word is taken only when insn[31:26] equals 19 and {insn[8], insn[5:1]} equals the parameter XO_MATCH. Otherwise not_mine_o is raised with the result, and all four write enables stay low.
- R2: An accepted word with insn[9] (the reserved immediate bit) set raises illegal_o, and all four write enables stay low.
- R3: The immediate insn[15:10] is biased by one. Encoded 0 means length 1 and encoded 63 means length 64. With insn[7]=1 and source field insn[20:16]=0, the requested length is this biased value.
- R4: With insn[7]=0 the requested length is the current vector length vl_i, and the source register is ignored.
- R5: With insn[7]=1 and a nonzero source field, the requested length is ra_val_i taken as an unsigned 64-bit value. Any value at or above the maximum yields the maximum.
- R6: With insn[6]=1 the new maximum is the biased immediate. With insn[6]=0 it is mvl_i unchanged.
- R7: An executed word writes both special registers (vl_we_o and mvl_we_o high), with vl_o equal to the minimum of the requested length and the new maximum.
- R8: The destination field insn[25:21] is written with the final length, zero-extended, only when it is nonzero (rd_we_o, rd_addr_o, rd_data_o).
- R9: When insn[0] is set, cr_we_o rises and cr0_o = {LT, GT, EQ, SO} (bits 3..0). LT, GT and EQ come from a signed comparison of the final length with zero, and SO copies so_i.
- R10: Every result is registered. valid_o is high exactly one cycle after valid_i, and all flags and enables are zero when valid_o is low. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Value of the register named by the source field |
| vl_i | input | 7 | Current vector length |
| mvl_i | input | 7 | Current maximum vector length |
| so_i | input | 1 | Summary-overflow bit |
| valid_o | output | 1 | Result valid |
| not_mine_o | output | 1 | Word does not belong to this unit |
| illegal_o | output | 1 | Reserved bit set |
| vl_we_o | output | 1 | Vector-length write enable |
| vl_o | output | 7 | New vector length |
| mvl_we_o | output | 1 | Maximum-length write enable |
| mvl_o | output | 7 | New maximum length |
| rd_we_o | output | 1 | Destination-register write enable |
| rd_addr_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Destination register data |
| cr_we_o | output | 1 | Condition field 0 write enable |
| cr0_o | output | 4 | Condition field 0 value {LT,GT,EQ,SO} |

## Verification
Every result is due on the first rising edge after the edge that samples valid_i. The bench drives each request on a falling edge and compares all outputs 1 ns after the next rising edge. An idle cycle is checked the same way, to confirm that the flags and enables drop back to zero one cycle after valid_i falls. The bench sweeps every immediate under all four mode-bit combinations. Each of these runs with a zero source field, a small register value and a huge unsigned register value. The destination field and the condition bit are varied as well. Expected values come from a min/bias model written in the bench.

// File: rtl/vl_cfg_pkg.sv
package vl_cfg_pkg;
  localparam logic [5:0] PRIMARY_OP = 6'd19;

  typedef struct packed {
    logic [4:0] rt;
    logic [4:0] ra;
    logic [5:0] imm;
    logic       vs;
    logic       ms;
    logic       rc;
  } fields_t;
endpackage

// File: rtl/vl_cfg_decode.sv
module vl_cfg_decode
  import vl_cfg_pkg::*;
#(
  parameter logic [5:0] XO_MATCH = 6'b010110
) (
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  output fields_t     fields_o,
  output logic        exec_o,
  output logic        not_mine_o,
  output logic        illegal_o
);
  logic       op_hit;
  logic       xo_hit;
  logic       rsvd;

  // bit k (MSB-first numbering) lives at insn_i[31-k]
  assign op_hit = (insn_i[31:26] == PRIMARY_OP);
  assign xo_hit = ({insn_i[8], insn_i[5:1]} == XO_MATCH);
  assign rsvd   = insn_i[9];

  always_comb begin
    fields_o.rt  = insn_i[25:21];
    fields_o.ra  = insn_i[20:16];
    fields_o.imm = insn_i[15:10];
    fields_o.vs  = insn_i[7];
    fields_o.ms  = insn_i[6];
    fields_o.rc  = insn_i[0];
  end

  assign not_mine_o = valid_i && !(op_hit && xo_hit);
  assign illegal_o  = valid_i && op_hit && xo_hit && rsvd;
  assign exec_o     = valid_i && op_hit && xo_hit && !rsvd;
endmodule

// File: rtl/vl_cfg_compute.sv
module vl_cfg_compute #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 6,
  localparam int unsigned LEN_W = IMM_W + 1
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             vs_i,
  input  logic             ms_i,
  input  logic             ra_nz_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [LEN_W-1:0] vl_i,
  input  logic [LEN_W-1:0] mvl_i,
  output logic [LEN_W-1:0] vl_o,
  output logic [LEN_W-1:0] mvl_o
);
  logic [LEN_W-1:0] imm_len;
  logic [XLEN-1:0]  req;
  logic [XLEN-1:0]  cap;

  assign imm_len = LEN_W'(imm_i) + LEN_W'(1);
  assign mvl_o   = ms_i ? imm_len : mvl_i;
  assign cap     = XLEN'(mvl_o);

  always_comb begin
    if (!vs_i)        req = XLEN'(vl_i);
    else if (ra_nz_i) req = ra_val_i;
    else              req = XLEN'(imm_len);
  end

  // unsigned compare over full width so huge register values clamp
  assign vl_o = (req < cap) ? req[LEN_W-1:0] : mvl_o;
endmodule

// File: rtl/vl_cfg_cr.sv
module vl_cfg_cr #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = 7
) (
  input  logic [LEN_W-1:0] vl_i,
  input  logic             so_i,
  output logic [3:0]       cr_o
);
  logic signed [XLEN-1:0] val;

  assign val  = $signed(XLEN'(vl_i));
  assign cr_o = {val < 0, val > 0, val == 0, so_i};
endmodule

// File: rtl/vl_cfg_unit.sv
module vl_cfg_unit
  import vl_cfg_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned IMM_W    = 6,
  parameter logic [5:0]  XO_MATCH = 6'b010110,
  localparam int unsigned LEN_W   = IMM_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      insn_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [LEN_W-1:0] vl_i,
  input  logic [LEN_W-1:0] mvl_i,
  input  logic             so_i,
  output logic             valid_o,
  output logic             not_mine_o,
  output logic             illegal_o,
  output logic             vl_we_o,
  output logic [LEN_W-1:0] vl_o,
  output logic             mvl_we_o,
  output logic [LEN_W-1:0] mvl_o,
  output logic             rd_we_o,
  output logic [4:0]       rd_addr_o,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             cr_we_o,
  output logic [3:0]       cr0_o
);
  fields_t          f;
  logic             exec, nm, ill;
  logic [LEN_W-1:0] vl_new, mvl_new;
  logic [3:0]       cr_new;

  vl_cfg_decode #(.XO_MATCH(XO_MATCH)) u_dec (
    .valid_i   (valid_i),
    .insn_i    (insn_i),
    .fields_o  (f),
    .exec_o    (exec),
    .not_mine_o(nm),
    .illegal_o (ill)
  );

  vl_cfg_compute #(.XLEN(XLEN), .IMM_W(IMM_W)) u_cmp (
    .imm_i   (f.imm),
    .vs_i    (f.vs),
    .ms_i    (f.ms),
    .ra_nz_i (f.ra != 5'd0),
    .ra_val_i(ra_val_i),
    .vl_i    (vl_i),
    .mvl_i   (mvl_i),
    .vl_o    (vl_new),
    .mvl_o   (mvl_new)
  );

  vl_cfg_cr #(.XLEN(XLEN), .LEN_W(LEN_W)) u_cr (
    .vl_i(vl_new),
    .so_i(so_i),
    .cr_o(cr_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      not_mine_o <= 1'b0;
      illegal_o  <= 1'b0;
      vl_we_o    <= 1'b0;
      mvl_we_o   <= 1'b0;
      rd_we_o    <= 1'b0;
      cr_we_o    <= 1'b0;
      vl_o       <= '0;
      mvl_o      <= '0;
      rd_addr_o  <= '0;
      rd_data_o  <= '0;
      cr0_o      <= '0;
    end else begin
      valid_o    <= valid_i;
      not_mine_o <= nm;
      illegal_o  <= ill;
      vl_we_o    <= exec;
      mvl_we_o   <= exec;
      rd_we_o    <= exec && (f.rt != 5'd0);
      cr_we_o    <= exec && f.rc;
      if (exec) begin
        vl_o      <= vl_new;
        mvl_o     <= mvl_new;
        rd_addr_o <= f.rt;
        rd_data_o <= XLEN'(vl_new);
        cr0_o     <= cr_new;
      end
    end
  end

  p_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(not_mine_o || illegal_o || vl_we_o || mvl_we_o || rd_we_o || cr_we_o));
  p_foreign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_mine_o |-> !(vl_we_o || mvl_we_o || rd_we_o || cr_we_o || illegal_o));
  p_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(vl_we_o || mvl_we_o || rd_we_o || cr_we_o));
  p_keep_vl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !f.vs) |=> (vl_o <= $past(vl_i)));
  p_keep_mvl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !f.ms) |=> (mvl_o == $past(mvl_i)));
  p_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_we_o |-> (mvl_we_o && vl_o <= mvl_o));
  p_rd_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_addr_o != 5'd0 && rd_data_o == XLEN'(vl_o)));
  p_cr_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (!cr0_o[3] && cr0_o[1] == (vl_o == '0) && cr0_o[2] == (vl_o != '0)));
endmodule

// File: tb/vl_cfg_unit_tb.sv
module vl_cfg_unit_tb;
  localparam logic [5:0] XO = 6'b010110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] ra_val = '0;
  logic [6:0]  vl_in = '0, mvl_in = '0;
  logic        so = 1'b0;
  logic        valid_o, not_mine_o, illegal_o, vl_we_o, mvl_we_o, rd_we_o, cr_we_o;
  logic [6:0]  vl_o, mvl_o;
  logic [4:0]  rd_addr_o;
  logic [63:0] rd_data_o;
  logic [3:0]  cr0_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vl_cfg_unit #(.XO_MATCH(XO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn), .ra_val_i(ra_val),
    .vl_i(vl_in), .mvl_i(mvl_in), .so_i(so), .valid_o(valid_o), .not_mine_o(not_mine_o),
    .illegal_o(illegal_o), .vl_we_o(vl_we_o), .vl_o(vl_o), .mvl_we_o(mvl_we_o),
    .mvl_o(mvl_o), .rd_we_o(rd_we_o), .rd_addr_o(rd_addr_o), .rd_data_o(rd_data_o),
    .cr_we_o(cr_we_o), .cr0_o(cr0_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
      input logic [4:0] ra, input logic [5:0] imm, input logic b22,
      input logic vs, input logic ms, input logic [5:0] xo, input logic rc);
    return {op, rt, ra, imm, b22, xo[5], vs, ms, xo[4:0], rc};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] rv,
                       input logic [6:0] v, input logic [6:0] m, input logic s);
    @(negedge clk);
    valid = 1'b1; insn = w; ra_val = rv; vl_in = v; mvl_in = m; so = s;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_none(input string req);
    chk({req, " vl_we"}, 64'(vl_we_o), 0);
    chk({req, " mvl_we"}, 64'(mvl_we_o), 0);
    chk({req, " rd_we"}, 64'(rd_we_o), 0);
    chk({req, " cr_we"}, 64'(cr_we_o), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    // R10 reset state
    chk("R10 reset valid", 64'(valid_o), 0);
    chk("R10 reset vl_we", 64'(vl_we_o), 0);
    chk("R10 reset rd_data", rd_data_o, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int imm = 0; imm < 64; imm++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int rsel = 0; rsel < 3; rsel++) begin
          for (int k = 0; k < 4; k++) begin
            logic vs, ms, rc;
            logic [4:0] rt, ra;
            logic [63:0] rv, req, e_mvl, e_vl;
            logic [6:0] vi, mi;
            logic s;
            vs = mode[1]; ms = mode[0]; rc = k[1];
            rt = k[0] ? 5'(imm % 31 + 1) : 5'd0;
            ra = (rsel == 0) ? 5'd0 : (rsel == 1) ? 5'd3 : 5'd17;
            rv = (rsel == 0) ? 64'hDEAD : (rsel == 1) ? 64'((imm * 3) % 70)
                                                      : (64'h8000_0000_0000_0000 | 64'(imm));
            vi = 7'((imm * 7 + mode) % 65);
            mi = 7'((imm * 13 + rsel * 5) % 64 + 1);
            s  = imm[0] ^ k[0];
            e_mvl = ms ? 64'(imm + 1) : 64'(mi);
            req = !vs ? 64'(vi) : (ra != 0) ? rv : 64'(imm + 1);
            e_vl = (req < e_mvl) ? req : e_mvl;
            issue(mk(6'd19, rt, ra, 6'(imm), 1'b0, vs, ms, XO, rc), rv, vi, mi, s);
            chk("R10 valid", 64'(valid_o), 1);
            chk("R1 not_mine", 64'(not_mine_o), 0);
            chk("R2 illegal", 64'(illegal_o), 0);
            chk("R6 mvl", 64'(mvl_o), e_mvl);
            if (!vs) chk("R4 vl", 64'(vl_o), e_vl);
            else if (ra != 0) chk("R5 vl", 64'(vl_o), e_vl);
            else chk("R3 vl", 64'(vl_o), e_vl);
            chk("R7 we", {vl_we_o, mvl_we_o}, 2'b11);
            chk("R8 rd_we", 64'(rd_we_o), 64'(rt != 0));
            if (rt != 0) begin
              chk("R8 rd_addr", 64'(rd_addr_o), 64'(rt));
              chk("R8 rd_data", rd_data_o, e_vl);
            end
            chk("R9 cr_we", 64'(cr_we_o), 64'(rc));
            if (rc) chk("R9 cr0", 64'(cr0_o), 64'({1'b0, e_vl != 0, e_vl == 0, s}));
          end
        end
      end
    end

    // R1 foreign opcode and foreign extended bits
    issue(mk(6'd18, 5'd4, 5'd0, 6'd5, 1'b0, 1'b1, 1'b1, XO, 1'b1), 0, 7'd3, 7'd9, 1'b0);
    chk("R1 op not_mine", 64'(not_mine_o), 1);
    expect_none("R1 op");
    for (int b = 0; b < 6; b++) begin
      issue(mk(6'd19, 5'd4, 5'd0, 6'd5, 1'b0, 1'b1, 1'b1, XO ^ (6'd1 << b), 1'b1),
            0, 7'd3, 7'd9, 1'b0);
      chk("R1 xo not_mine", 64'(not_mine_o), 1);
      expect_none("R1 xo");
    end

    // R2 reserved bit
    issue(mk(6'd19, 5'd4, 5'd2, 6'd5, 1'b1, 1'b1, 1'b1, XO, 1'b1), 40, 7'd3, 7'd9, 1'b1);
    chk("R2 illegal set", 64'(illegal_o), 1);
    chk("R2 not_mine", 64'(not_mine_o), 0);
    expect_none("R2");

    // R10 idle cycle after request
    @(negedge clk);
    valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 idle valid", 64'(valid_o), 0);
    chk("R10 idle flags", {not_mine_o, illegal_o}, 0);
    expect_none("R10 idle");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule